// File: doc/BRIEF.md
# Codec Power-State Controller

This block decides, cycle by cycle in the master-clock domain, whether a voice codec channel is fully active, running as a half channel (transmit only), or parked in low-power standby. It watches the transmit and receive frame syncs and a power-up pin. From them it drives enables for the transmit and receive signal paths, a mute that ties the receive filter input to analog ground, and a permit that lets the serial data output leave high impedance.

Standby is entered when the power-up pin is low, or when neither frame sync shows a rising edge for a whole frame while the master clock keeps running. Leaving standby needs the power-up pin high and a transmit sync edge. After waking, the serial output stays released from the bus for a fixed number of transmit frames, so that it cannot collide with another driver. The receive path switches to half-channel operation when the receive sync stops toggling and returns as soon as it toggles again.

All inputs are asynchronous to the master clock and pass through two flip-flops before use. The syncs are then edge-detected. Counters measure the idle windows in master-clock cycles.

Top module: `pwr_state_ctl`

## Requirements
- R1: While active, the block enters standby (all outputs low) once IDLE_LIMIT (default 600) consecutive master-clock cycles pass with no rising edge on either frame sync; a gap shorter than that keeps it active.
- R2: A low level on the power-up pin forces standby within four master-clock cycles, and the block stays in standby while the pin is low, whatever the syncs do.
- R3: From standby, the block wakes only on a rising edge of the transmit sync while the power-up pin is high; receive sync edges alone do not wake it.
- R4: After the waking edge, ser_out_ok stays low until WAKE_FRAMES (default 2) further transmit sync rising edges have been seen, then goes high.
- R5: While active, if the receive sync shows no rising edge for IDLE_LIMIT cycles, rx_en goes low and rx_mute goes high while tx_en stays high (half channel).
- R6: In half channel, a receive sync rising edge returns the block to full operation (rx_en high, rx_mute low) within four cycles.
- R7: In standby all four outputs are low and the post-wake frame count is cleared, so every wake-up waits the full WAKE_FRAMES again.
- R8: After reset the block is in standby with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tx | input | 1 | Transmit frame sync, asynchronous |
| fs_rx | input | 1 | Receive frame sync, asynchronous |
| pwr_up | input | 1 | Power-up pin, high requests operation |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |
| rx_mute | output | 1 | Tie receive filter input to analog ground |
| ser_out_ok | output | 1 | Serial output may drive the bus |

## Verification
A stuck or mis-cleared idle counter shows at the ports as a channel that drops to standby while syncs still arrive, or that never drops. Either shows within one idle window of about 600 cycles. A wrong wake counter shows as ser_out_ok rising one frame early or late after a wake, and is visible at the first or second transmit frame. Half-channel faults appear as rx_en and rx_mute out of step with the receive sync. Such faults are caught within one idle window of the receive sync stopping, or within a few cycles of it restarting.

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int IDLE_LIMIT  = 600,
  parameter int WAKE_FRAMES = 2
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic fs_tx,
  input  logic fs_rx,
  input  logic pwr_up,
  output logic tx_en,
  output logic rx_en,
  output logic rx_mute,
  output logic ser_out_ok
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam int FW = $clog2(WAKE_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_LIMIT - 1);
  localparam logic [FW-1:0] WDONE = FW'(WAKE_FRAMES);

  logic [2:0] tx_sh, rx_sh;
  logic [1:0] pu_sh;
  logic active, rx_live;
  logic [CW-1:0] idle_cnt, rx_cnt;
  logic [FW-1:0] wcnt;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      pu_sh <= '0;
    end else begin
      tx_sh <= {tx_sh[1:0], fs_tx};
      rx_sh <= {rx_sh[1:0], fs_rx};
      pu_sh <= {pu_sh[0], pwr_up};
    end

  wire tx_rise  = tx_sh[1] & ~tx_sh[2];
  wire rx_rise  = rx_sh[1] & ~rx_sh[2];
  wire any_rise = tx_rise | rx_rise;
  wire pu_ok    = pu_sh[1];

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      active   <= 1'b0;
      rx_live  <= 1'b0;
      idle_cnt <= '0;
      rx_cnt   <= '0;
      wcnt     <= '0;
    end else if (!active) begin
      idle_cnt <= '0;
      rx_cnt   <= '0;
      wcnt     <= '0;
      rx_live  <= 1'b0;
      if (pu_ok && tx_rise) begin
        active  <= 1'b1;
        rx_live <= rx_rise;
      end
    end else if (!pu_ok || (!any_rise && idle_cnt == LAST)) begin
      active   <= 1'b0;
      rx_live  <= 1'b0;
      idle_cnt <= '0;
      rx_cnt   <= '0;
      wcnt     <= '0;
    end else begin
      idle_cnt <= any_rise ? '0 : idle_cnt + 1'b1;
      if (rx_rise) begin
        rx_cnt  <= '0;
        rx_live <= 1'b1;
      end else if (rx_cnt == LAST) begin
        rx_live <= 1'b0;
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
      end
      if (tx_rise && wcnt != WDONE) wcnt <= wcnt + 1'b1;
    end

  assign tx_en      = active;
  assign rx_en      = active & rx_live;
  assign rx_mute    = active & ~rx_live;
  assign ser_out_ok = active & (wcnt == WDONE);

  AST_IDLE_BOUND: assert property (@(posedge mclk) disable iff (!rst_n)
    idle_cnt < CW'(IDLE_LIMIT)); // R1
  AST_PIN_LOW_SLEEPS: assert property (@(posedge mclk) disable iff (!rst_n)
    !pu_ok |=> !tx_en); // R2
  AST_WAKE_ON_TX: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(tx_rise) && $past(pu_ok))); // R3
  AST_PERMIT_ON_TX: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ser_out_ok) |-> $past(tx_rise)); // R4
  AST_RX_RETURN: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_en && rx_rise && pu_ok) |=> (rx_en && !rx_mute)); // R6
  AST_STBY_COUNT_CLEAR: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(tx_en) |=> !ser_out_ok); // R7
endmodule

// File: tb/sim_pwr_state_ctl.sv
module sim_pwr_state_ctl;
  logic mclk = 1'b0, rst_n = 1'b0, fs_tx = 1'b0, fs_rx = 1'b0, pwr_up = 1'b0;
  logic tx_en, rx_en, rx_mute, ser_out_ok;
  int n_chk = 0, n_bad = 0;
  logic [3:0] exq[$];
  string rq[$];
  bit done = 1'b0;

  always #10 mclk = ~mclk;

  pwr_state_ctl u0 (.mclk(mclk), .rst_n(rst_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .pwr_up(pwr_up), .tx_en(tx_en), .rx_en(rx_en), .rx_mute(rx_mute),
    .ser_out_ok(ser_out_ok));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  // expected order: {tx_en, rx_en, rx_mute, ser_out_ok}
  task automatic expect_now(input logic [3:0] e, input string req);
    #2;
    exq.push_back(e);
    rq.push_back(req);
  endtask

  task automatic frame(input bit tx, input bit rx);
    @(negedge mclk);
    fs_tx = tx;
    fs_rx = rx;
    wait_cyc(8);
    fs_tx = 1'b0;
    fs_rx = 1'b0;
    wait_cyc(92);
  endtask

  initial begin : monitor
    forever begin
      @(negedge mclk);
      while (exq.size() > 0) begin
        logic [3:0] e, a;
        string r;
        e = exq.pop_front();
        r = rq.pop_front();
        a = {tx_en, rx_en, rx_mute, ser_out_ok};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s actual=%b expected=%b", r, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    expect_now(4'b0000, "R8 reset standby");
    pwr_up = 1'b1;
    wait_cyc(50);
    expect_now(4'b0000, "R3 no wake without sync");
    frame(1'b0, 1'b1);
    frame(1'b0, 1'b1);
    expect_now(4'b0000, "R3 rx sync alone");
    frame(1'b1, 1'b1);
    expect_now(4'b1100, "R3 wake on tx");
    frame(1'b1, 1'b1);
    expect_now(4'b1100, "R4 one frame held");
    frame(1'b1, 1'b1);
    expect_now(4'b1101, "R4 permit after two");
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    expect_now(4'b1101, "R5 short rx gap");
    for (int i = 0; i < 5; i++) frame(1'b1, 1'b0);
    expect_now(4'b1011, "R5 half channel");
    @(negedge mclk);
    fs_tx = 1'b1;
    fs_rx = 1'b1;
    wait_cyc(7);
    expect_now(4'b1101, "R6 rx returns");
    fs_tx = 1'b0;
    fs_rx = 1'b0;
    wait_cyc(92);
    wait_cyc(400);
    expect_now(4'b1101, "R1 gap below limit");
    wait_cyc(200);
    expect_now(4'b0000, "R1 idle standby");
    frame(1'b1, 1'b1);
    expect_now(4'b1100, "R7 count cleared");
    pwr_up = 1'b0;
    wait_cyc(5);
    expect_now(4'b0000, "R2 pin low");
    frame(1'b1, 1'b1);
    frame(1'b1, 1'b1);
    expect_now(4'b0000, "R2 held while low");
    pwr_up = 1'b1;
    wait_cyc(4);
    frame(1'b1, 1'b1);
    expect_now(4'b1100, "R7 rewake waits");
    wait_cyc(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule